// File: doc/BRIEF.md
# Dual-Lane Significand Alignment Right Shifter

This block aligns the addend significand of a fused multiply-add datapath before it meets the product. It takes a 161-bit word with the addend already placed at the top of its field and moves it right by a count that the exponent logic has computed. In wide mode the whole word moves as one. In split mode the same hardware works as two independent 74-bit right shifters: one on bits [73:0] and one on bits [148:75], each with its own count.

Every shift stage is split into slices by bit position. The slice above the upper lane base picks its control bit from the upper-lane count in split mode. The bits next to the lane boundary take in zeros rather than upper-lane bits. Only zeros enter from the top, because any complementing for subtraction is done downstream. For each lane, a sticky flag collects every one-bit that is shifted past the bottom of that lane. The result and the flags are registered once.

Top module: `align_shift_dual`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state of `data_out`, `sticky_lo` and `sticky_hi` is all zeros.
- R2: Results appear exactly one clock edge after the inputs are presented; before that edge the outputs keep their previous values.
- R3: With `mode_dbl` = 1 (wide mode), `data_out` equals `data_in` shifted right by `cnt_dbl` (0 to 255) with zero fill; any count of 161 or more gives zero.
- R4: In wide mode, `sticky_lo` is the OR of all `data_in` bits below bit position `cnt_dbl` (all bits for counts of 161 or more), and `sticky_hi` is 0.
- R5: With `mode_dbl` = 0 (split mode), `data_out[73:0]` equals `data_in[73:0]` shifted right by `cnt_lo` (0 to 127) with zero fill; counts of 74 or more give zero, and no upper-lane bit ever enters the lower lane.
- R6: In split mode, `data_out[148:75]` equals `data_in[148:75]` shifted right by `cnt_hi` (0 to 127) with zero fill; counts of 74 or more give zero.
- R7: In split mode, `data_out[74]` and `data_out[160:149]` are zero, whatever `data_in` holds there.
- R8: In split mode, `sticky_lo` is the OR of the `data_in[73:0]` bits below position `cnt_lo`, and `sticky_hi` is the OR of the `data_in[148:75]` bits below lane position `cnt_hi`.
- R9: `cnt_dbl` has no effect in split mode, and `cnt_lo` and `cnt_hi` have no effect in wide mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_dbl | input | 1 | 1 = one wide shift, 0 = two split lanes |
| data_in | input | 161 | Placed addend word |
| cnt_dbl | input | 8 | Shift count for wide mode |
| cnt_lo | input | 7 | Shift count for the lower lane in split mode |
| cnt_hi | input | 7 | Shift count for the upper lane in split mode |
| data_out | output | 161 | Aligned word, registered |
| sticky_lo | output | 1 | Lost-bit flag for the wide word or the lower lane |
| sticky_hi | output | 1 | Lost-bit flag for the upper lane |

## Verification
The hardest case to reach is split mode with two different counts while the lower lane sits under a fully populated upper lane. Only then would a mis-sliced stage let upper-lane bits spill across bit 74 or steer the wrong count bit. The bench sweeps every pair of lane counts from 0 to 127, filling both lanes and the gap bits with random or all-ones data. This pushes each stage's center slice to both settings while its neighbour slice takes the other. Wide mode is swept over every count up to 255 with several fill patterns, so the 128 stage and the counts beyond the word width are reached.

// File: rtl/align_pkg.sv
// Shared definitions for the dual-lane alignment shifter.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package align_pkg;
    typedef enum logic {
        MODE_SGL = 1'b0,
        MODE_DBL = 1'b1
    } align_mode_e;

    // Number of bits needed to hold values 0..n
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/align_stage.sv
// One power-of-two stage of the segmented right shifter.
// Bits at or above the upper lane base follow sel_hi_eff; all lower bits follow
// sel_lo_eff. The center slice (sources in the upper region, destinations below it)
// takes zeros in split mode. Zeros enter from the top of the word.
// Assumes: the caller has already merged the mode into the two select inputs.
module align_stage #(
    parameter int WIDE_W = 161,
    parameter int LANE_W = 74,
    parameter int SHIFT  = 1
) (
    input  logic [WIDE_W-1:0] din,
    input  logic              dbl,
    input  logic              sel_lo_eff,
    input  logic              sel_hi_eff,
    output logic [WIDE_W-1:0] dout,
    output logic              lost_lo,
    output logic              lost_hi
);
    localparam int HI_BASE = LANE_W + 1;
    localparam int LOSTL_W = (SHIFT < WIDE_W) ? SHIFT : WIDE_W;
    localparam int LOSTH_W = (SHIFT < WIDE_W - HI_BASE) ? SHIFT : WIDE_W - HI_BASE;

    logic [WIDE_W-1:0] src;

    for (genvar j = 0; j < WIDE_W; j++) begin : g_bit
        localparam int SRC = j + SHIFT;
        if (SRC >= WIDE_W) begin : g_top
            assign src[j] = 1'b0;
        end else if (j >= HI_BASE) begin : g_msl
            assign src[j] = din[SRC];
        end else if (SRC >= HI_BASE) begin : g_ctr
            assign src[j] = dbl ? din[SRC] : 1'b0;
        end else begin : g_lsl
            assign src[j] = din[SRC];
        end
        if (j >= HI_BASE) begin : g_sel_hi
            assign dout[j] = sel_hi_eff ? src[j] : din[j];
        end else begin : g_sel_lo
            assign dout[j] = sel_lo_eff ? src[j] : din[j];
        end
    end

    // Bits leaving the bottom of the word (wide) or of the lower lane (split)
    assign lost_lo = sel_lo_eff & (|din[LOSTL_W-1:0]);
    // Bits leaving the bottom of the upper lane, split mode only
    assign lost_hi = ~dbl & sel_hi_eff & (|din[HI_BASE+LOSTH_W-1:HI_BASE]);
endmodule

// File: rtl/align_core.sv
// Combinational chain of shift stages with the weights 1, 2, 4 and upward.
// In split mode, the lane gap bit and the bits above the upper lane are cleared
// on entry, and stages beyond the lane count width are held inactive.
// Assumes: WIDE_W > 2*LANE_W + 1.
module align_core
    import align_pkg::*;
#(
    parameter int WIDE_W = 161,
    parameter int LANE_W = 74,
    localparam int DCW = cnt_bits(WIDE_W),
    localparam int LCW = cnt_bits(LANE_W)
) (
    input  logic [WIDE_W-1:0] din,
    input  logic              dbl,
    input  logic [DCW-1:0]    cnt_dbl,
    input  logic [LCW-1:0]    cnt_lo,
    input  logic [LCW-1:0]    cnt_hi,
    output logic [WIDE_W-1:0] dout,
    output logic              stk_lo,
    output logic              stk_hi
);
    localparam int NSTG = DCW;

    logic [WIDE_W-1:0] masked;
    logic [NSTG:0][WIDE_W-1:0] stg;
    logic [NSTG-1:0] lost_lo, lost_hi;

    // Clear the gap bit and the region above the upper lane in split mode
    always_comb begin
        masked = din;
        if (!dbl) begin
            masked[LANE_W] = 1'b0;
            masked[WIDE_W-1:2*LANE_W+1] = '0;
        end
    end

    assign stg[0] = masked;

    for (genvar i = 0; i < NSTG; i++) begin : g_stg
        logic sl, sh;
        if (i < LCW) begin : g_act
            assign sl = dbl ? cnt_dbl[i] : cnt_lo[i];
            assign sh = dbl ? cnt_dbl[i] : cnt_hi[i];
        end else begin : g_wide_only
            assign sl = dbl & cnt_dbl[i];
            assign sh = dbl & cnt_dbl[i];
        end
        align_stage #(
            .WIDE_W(WIDE_W),
            .LANE_W(LANE_W),
            .SHIFT (1 << i)
        ) u_stage (
            .din       (stg[i]),
            .dbl       (dbl),
            .sel_lo_eff(sl),
            .sel_hi_eff(sh),
            .dout      (stg[i+1]),
            .lost_lo   (lost_lo[i]),
            .lost_hi   (lost_hi[i])
        );
    end

    assign dout   = stg[NSTG];
    assign stk_lo = |lost_lo;
    assign stk_hi = |lost_hi;
endmodule

// File: rtl/align_shift_dual.sv
// Top of the dual-lane alignment shifter: the shift chain plus one output register.
// Assumes: the counts come from the exponent logic already clamped or sized.
module align_shift_dual
    import align_pkg::*;
#(
    parameter int WIDE_W = 161,
    parameter int LANE_W = 74,
    localparam int DCW = cnt_bits(WIDE_W),
    localparam int LCW = cnt_bits(LANE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dbl,
    input  logic [WIDE_W-1:0] data_in,
    input  logic [DCW-1:0]    cnt_dbl,
    input  logic [LCW-1:0]    cnt_lo,
    input  logic [LCW-1:0]    cnt_hi,
    output logic [WIDE_W-1:0] data_out,
    output logic              sticky_lo,
    output logic              sticky_hi
);
    logic [WIDE_W-1:0] sh_word;
    logic sh_stk_lo, sh_stk_hi;
    logic is_dbl;

    assign is_dbl = (align_mode_e'(mode_dbl) == MODE_DBL);

    align_core #(
        .WIDE_W(WIDE_W),
        .LANE_W(LANE_W)
    ) u_core (
        .din    (data_in),
        .dbl    (is_dbl),
        .cnt_dbl(cnt_dbl),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .dout   (sh_word),
        .stk_lo (sh_stk_lo),
        .stk_hi (sh_stk_hi)
    );

    // Register the aligned word and both lost-bit flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '0;
            sticky_lo <= 1'b0;
            sticky_hi <= 1'b0;
        end else begin
            data_out  <= sh_word;
            sticky_lo <= sh_stk_lo;
            sticky_hi <= sh_stk_hi;
        end
    end
endmodule

// File: rtl/align_shift_chk.sv
// Property checker for align_shift_dual, attached by bind below.
// Assumes: the same parameter values as the module it is bound to.
module align_shift_chk
    import align_pkg::*;
#(
    parameter int WIDE_W = 161,
    parameter int LANE_W = 74,
    localparam int DCW = cnt_bits(WIDE_W),
    localparam int LCW = cnt_bits(LANE_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_dbl,
    input logic [WIDE_W-1:0] data_in,
    input logic [DCW-1:0]    cnt_dbl,
    input logic [LCW-1:0]    cnt_lo,
    input logic [LCW-1:0]    cnt_hi,
    input logic [WIDE_W-1:0] data_out,
    input logic              sticky_lo,
    input logic              sticky_hi
);
    AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dbl && cnt_dbl == '0) |=> (data_out == $past(data_in) && !sticky_lo)); // R3
    AST_WIDE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dbl && cnt_dbl >= DCW'(WIDE_W)) |=> (data_out == '0 && sticky_lo == $past(|data_in))); // R4
    AST_WIDE_NO_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dbl |=> !sticky_hi); // R4
    AST_LO_LANE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dbl && cnt_lo >= LCW'(LANE_W)) |=> (data_out[LANE_W-1:0] == '0 && sticky_lo == $past(|data_in[LANE_W-1:0]))); // R5
    AST_HI_LANE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dbl && cnt_hi >= LCW'(LANE_W)) |=> (data_out[2*LANE_W:LANE_W+1] == '0 && sticky_hi == $past(|data_in[2*LANE_W:LANE_W+1]))); // R6
    AST_SPLIT_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dbl |=> (!data_out[LANE_W] && data_out[WIDE_W-1:2*LANE_W+1] == '0)); // R7
endmodule

bind align_shift_dual align_shift_chk #(
    .WIDE_W(WIDE_W),
    .LANE_W(LANE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_dbl (mode_dbl),
    .data_in  (data_in),
    .cnt_dbl  (cnt_dbl),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .data_out (data_out),
    .sticky_lo(sticky_lo),
    .sticky_hi(sticky_hi)
);

// File: tb/tb_align_shift_dual.sv
// Self-checking sweep bench for align_shift_dual.
module tb_align_shift_dual;
    localparam int CLK_PERIOD = 10;
    localparam int W = 161;
    localparam int L = 74;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_dbl = 1'b1;
    logic [W-1:0] data_in = '0;
    logic [7:0] cnt_dbl = '0;
    logic [6:0] cnt_lo = '0;
    logic [6:0] cnt_hi = '0;
    logic [W-1:0] data_out;
    logic sticky_lo, sticky_hi;

    int n_run = 0;
    int n_fail = 0;

    align_shift_dual dut (
        .clk(clk), .rst_n(rst_n), .mode_dbl(mode_dbl), .data_in(data_in),
        .cnt_dbl(cnt_dbl), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .data_out(data_out), .sticky_lo(sticky_lo), .sticky_hi(sticky_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic lost_bits(input logic [W-1:0] d, input int c);
        logic [255:0] e, m;
        e = 256'(d);
        m = (c >= 256) ? '1 : ((256'd1 << c) - 256'd1);
        return |(e & m);
    endfunction

    // Present inputs at a falling edge, let one rising edge pass, sample at the next fall
    task automatic apply(input logic md, input logic [W-1:0] d, input int cd, input int cl, input int ch);
        mode_dbl = md; data_in = d;
        cnt_dbl = 8'(cd); cnt_lo = 7'(cl); cnt_hi = 7'(ch);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_wide(input logic [W-1:0] d, input int cd, input string tag);
        logic [W-1:0] e;
        e = d >> cd;
        chk(data_out == e, {"R3 ", tag}, data_out, e);
        chk(sticky_lo == lost_bits(d, cd) && sticky_hi == 1'b0, {"R4 ", tag},
            W'({sticky_hi, sticky_lo}), W'({1'b0, lost_bits(d, cd)}));
    endtask

    task automatic check_split(input logic [W-1:0] d, input int cl, input int ch, input string tag);
        logic [L-1:0] lo, hi, elo, ehi;
        lo = d[L-1:0];
        hi = d[2*L:L+1];
        elo = lo >> cl;
        ehi = hi >> ch;
        chk(data_out[L-1:0] == elo, {"R5 ", tag}, W'(data_out[L-1:0]), W'(elo));
        chk(data_out[2*L:L+1] == ehi, {"R6 ", tag}, W'(data_out[2*L:L+1]), W'(ehi));
        chk(!data_out[L] && data_out[W-1:2*L+1] == '0, {"R7 ", tag},
            W'({data_out[W-1:2*L+1], data_out[L]}), '0);
        chk(sticky_lo == lost_bits(W'(lo), cl) && sticky_hi == lost_bits(W'(hi), ch), {"R8 ", tag},
            W'({sticky_hi, sticky_lo}), W'({lost_bits(W'(hi), ch), lost_bits(W'(lo), cl)}));
    endtask

    initial begin
        logic [W-1:0] d;
        // R1: reset with busy inputs
        mode_dbl = 1'b1; data_in = '1; cnt_dbl = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(data_out == '0 && !sticky_lo && !sticky_hi, "R1 reset state",
            W'({data_out, sticky_lo, sticky_hi}), '0);
        rst_n = 1'b1;

        // R2: output unchanged before the edge, updated after it
        apply(1'b1, W'(161'h5A5), 0, 0, 0);
        mode_dbl = 1'b1; data_in = '1; cnt_dbl = 8'd4;
        #1;
        chk(data_out == W'(161'h5A5), "R2 hold before edge", data_out, W'(161'h5A5));
        @(posedge clk); @(negedge clk);
        chk(data_out == ({W{1'b1}} >> 4), "R2 update after edge", data_out, {W{1'b1}} >> 4);

        // R3 R4: wide mode, every count, several fills; lane counts randomised (R9)
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 256; c++) begin
                case (p)
                    0: d = '1;
                    1: d = {81{2'b01}};
                    2: d = W'(1) << (c % W);
                    default: d = rnd_word();
                endcase
                apply(1'b1, d, c, int'($urandom_range(0, 127)), int'($urandom_range(0, 127)));
                check_wide(d, c, "wide sweep");
            end
        end

        // R5 R6 R7 R8: split mode, every pair of lane counts
        for (int cl = 0; cl < 128; cl++) begin
            for (int ch = 0; ch < 128; ch++) begin
                d = ((cl + ch) % 16 == 0) ? '1 : rnd_word();
                apply(1'b0, d, int'($urandom_range(0, 255)), cl, ch);
                check_split(d, cl, ch, "split sweep");
            end
        end

        // R9: unused counts varied with fixed data and used count
        for (int k = 0; k < 32; k++) begin
            d = rnd_word();
            apply(1'b0, d, k * 8, 13, 57);
            check_split(d, 13, 57, "R9 wide count ignored in split");
            apply(1'b1, d, 37, k * 4, 127 - k * 4);
            check_wide(d, 37, "R9 lane counts ignored in wide");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule